// File: doc/BRIEF.md
# Serial Interface Interrupt Flag Controller

This block keeps the transfer-interrupt flag and the DMA-start request flag for a byte-wide serial port whose transmit and receive data are double buffered. The shift engine sends it one-cycle strobes: transfer-clock rising edges, start and stop detection, slave-address or general-call match, and moves between the holding registers and the shift register. It also receives the framing mode, the direction and the levels of the transmit-empty and receive-full flags. From these inputs it decides when the interrupt flag and the DMA request flag set.

Software reaches the flags through one control register. The interrupt flag clears only by a handshake: a read that returns 1, followed by a write of 0. A DMA access to the data register clears both flags at once, so back-to-back DMA transfers run with no CPU action. Between an address match in I2C slave mode and the next repeated start or stop, the DMA request is held off while the interrupt flag still works as usual.

Top module: `sif_irq_ctrl`

## Requirements
- R1: In clocked synchronous mode (mode_i = 1), the interrupt flag sets on the clock after every 8th bit_clk_rise_i strobe, counted from reset, from leaving the other modes or from the last start strobe. The count then restarts.
- R2: In formatless mode (mode_i = 2), the interrupt flag sets after every 9th bit_clk_rise_i strobe and not after the 8th. A start strobe alone does not set it in this mode.
- R3: A start_det_i strobe sets the interrupt flag in clocked synchronous mode. In I2C mode (mode_i = 0) it does not set the flag unless R5 applies.
- R4: A register write with bit 3 = 1 sets the interrupt flag. Bit 3 always reads 0.
- R5: Each of the following sets both the interrupt flag and the DMA request flag, the DMA flag subject to R8, in every mode: a start strobe while tx_mode_i = 1 and tx_empty_i = 1; tx_move_i with tx_empty_i = 1; rx_move_i with rx_full_i = 1. A move without its level sets neither flag.
- R6: A register read that returns bit 0 = 1 arms a clear latch, and any register write disarms it. A write with bit 0 = 0 while the latch is armed clears both flags. A write of 0 while disarmed, or a write of 1, leaves the flags unchanged.
- R7: A dma_access_i strobe clears both the interrupt flag and the DMA request flag.
- R8: In I2C mode with slave_mode_i = 1, an addr_match_i strobe starts a hold window. From the next clock on, the R5 events set only the interrupt flag. A start or stop strobe ends the window.
- R9: When a set event and a clear event fall in the same clock cycle, the flag ends up set.
- R10: Register bit 2 is a read/write interrupt enable, and irq_o equals interrupt flag AND enable.
- R11: After reset, all flags, the enable, the clear latch and the bit count are 0. Read data is bit 0 = interrupt flag, bit 1 = DMA request flag, bit 2 = enable, and 0 in every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Framing mode: 0 I2C, 1 clocked synchronous, 2 formatless |
| tx_mode_i | input | 1 | Transmit direction selected |
| slave_mode_i | input | 1 | Slave role selected |
| bit_clk_rise_i | input | 1 | Transfer clock rising edge strobe |
| start_det_i | input | 1 | Start or repeated start detected strobe |
| stop_det_i | input | 1 | Stop detected strobe |
| addr_match_i | input | 1 | Slave address or general-call match strobe |
| tx_move_i | input | 1 | Transmit holding to shift register move strobe |
| rx_move_i | input | 1 | Shift to receive holding register move strobe |
| tx_empty_i | input | 1 | Transmit buffer empty level |
| rx_full_i | input | 1 | Receive buffer full level |
| dma_access_i | input | 1 | DMA read or write of the data register strobe |
| reg_rd_i | input | 1 | Control register read strobe |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| int_flag_o | output | 1 | Transfer interrupt flag |
| dma_req_o | output | 1 | DMA start request flag |
| irq_o | output | 1 | Interrupt line |

## Verification
Runs of bit-clock strobes are fed in clocked synchronous and formatless modes. These runs show whether the set lands on the 8th or the 9th edge and whether the count restarts after each byte and after a start. Each buffer-move event is given once with its level high and once with it low, in and out of the slave hold window, which separates the interrupt path from the DMA path. Clear sequences are tried with and without the arming read, with a write of 1 in between, and with a set event in the same cycle, so that the handshake, the disarm-on-write rule and the set priority can each be seen on their own.

// File: rtl/sif_irq_pkg.sv
package sif_irq_pkg;
  typedef enum logic [1:0] {
    MODE_I2C     = 2'd0,
    MODE_SYNC    = 2'd1,
    MODE_FMTLESS = 2'd2
  } sif_mode_e;

  localparam int unsigned FLAG_BIT = 0;
  localparam int unsigned DMA_BIT  = 1;
  localparam int unsigned EN_BIT   = 2;
  localparam int unsigned SW_BIT   = 3;
  localparam int unsigned NUM_FLAGS = 2;
endpackage

// File: rtl/sif_bit_counter.sv
module sif_bit_counter
  import sif_irq_pkg::*;
#(
  parameter int unsigned SYNC_BITS = 8,
  parameter int unsigned FMT_BITS  = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       rise_i,
  input  logic       start_i,
  output logic       fire_o
);
  localparam int unsigned MAX_BITS = (SYNC_BITS > FMT_BITS) ? SYNC_BITS : FMT_BITS;
  localparam int unsigned CNT_W    = $clog2(MAX_BITS + 1);

  logic [CNT_W-1:0] cnt_q, last_c;
  logic             active;

  always_comb begin
    active = (mode_i == MODE_SYNC) || (mode_i == MODE_FMTLESS);
    last_c = (mode_i == MODE_SYNC) ? CNT_W'(SYNC_BITS - 1) : CNT_W'(FMT_BITS - 1);
  end

  assign fire_o = active && rise_i && !start_i && (cnt_q >= last_c);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!active || start_i) cnt_q <= '0;
    else if (rise_i)            cnt_q <= fire_o ? '0 : cnt_q + 1'b1;
  end

  assert_cnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_BITS - 1));
endmodule

// File: rtl/sif_addr_hold.sv
module sif_addr_hold
  import sif_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       slave_i,
  input  logic       match_i,
  input  logic       start_i,
  input  logic       stop_i,
  output logic       hold_o
);
  logic open_c;
  assign open_c = match_i && slave_i && (mode_i == MODE_I2C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               hold_o <= 1'b0;
    else if (open_c)           hold_o <= 1'b1;
    else if (start_i || stop_i) hold_o <= 1'b0;
  end
endmodule

// File: rtl/sif_flag_cell.sv
module sif_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set has priority so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/sif_irq_ctrl.sv
module sif_irq_ctrl
  import sif_irq_pkg::*;
#(
  parameter int unsigned SYNC_BITS = 8,
  parameter int unsigned FMT_BITS  = 9,
  parameter int unsigned REG_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             tx_mode_i,
  input  logic             slave_mode_i,
  input  logic             bit_clk_rise_i,
  input  logic             start_det_i,
  input  logic             stop_det_i,
  input  logic             addr_match_i,
  input  logic             tx_move_i,
  input  logic             rx_move_i,
  input  logic             tx_empty_i,
  input  logic             rx_full_i,
  input  logic             dma_access_i,
  input  logic             reg_rd_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             int_flag_o,
  output logic             dma_req_o,
  output logic             irq_o
);
  logic fire, hold_q, arm_q, en_q;
  logic buf_ev, int_set, dma_set, cpu_clr, flag_clr;
  logic [NUM_FLAGS-1:0] set_v, q_v;

  sif_bit_counter #(.SYNC_BITS(SYNC_BITS), .FMT_BITS(FMT_BITS)) u_cnt (
    .clk_i, .rst_ni, .mode_i, .rise_i(bit_clk_rise_i), .start_i(start_det_i), .fire_o(fire)
  );

  sif_addr_hold u_hold (
    .clk_i, .rst_ni, .mode_i, .slave_i(slave_mode_i), .match_i(addr_match_i),
    .start_i(start_det_i), .stop_i(stop_det_i), .hold_o(hold_q)
  );

  always_comb begin
    buf_ev  = (start_det_i && tx_mode_i && tx_empty_i)
            || (tx_move_i && tx_empty_i)
            || (rx_move_i && rx_full_i);
    int_set = fire || (start_det_i && (mode_i == MODE_SYNC))
            || (reg_wr_i && reg_wdata_i[SW_BIT]) || buf_ev;
    dma_set = buf_ev && !hold_q;
    cpu_clr = reg_wr_i && !reg_wdata_i[FLAG_BIT] && arm_q;
    flag_clr = cpu_clr || dma_access_i;
  end

  assign set_v[FLAG_BIT] = int_set;
  assign set_v[DMA_BIT]  = dma_set;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    sif_flag_cell u_cell (
      .clk_i, .rst_ni, .set_i(set_v[g]), .clr_i(flag_clr), .q_o(q_v[g])
    );
  end

  assign int_flag_o = q_v[FLAG_BIT];
  assign dma_req_o  = q_v[DMA_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      if (reg_wr_i) begin
        arm_q <= 1'b0;
        en_q  <= reg_wdata_i[EN_BIT];
      end else if (reg_rd_i && int_flag_o) begin
        arm_q <= 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata_o           = '0;
    reg_rdata_o[FLAG_BIT] = int_flag_o;
    reg_rdata_o[DMA_BIT]  = dma_req_o;
    reg_rdata_o[EN_BIT]   = en_q;
  end

  assign irq_o = int_flag_o && en_q;

  assert_wr1_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_flag_o && reg_wr_i && reg_wdata_i[FLAG_BIT] && !dma_access_i |=> int_flag_o);
  assert_unarmed_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_flag_o && !arm_q && !dma_access_i |=> int_flag_o);
  assert_dma_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_access_i && !int_set |=> !int_flag_o && !dma_req_o);
  assert_hold_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q && !dma_req_o |=> !dma_req_o);
  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_set |=> int_flag_o);
  assert_irq_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> int_flag_o);
endmodule

// File: tb/sif_irq_ctrl_test.sv
`timescale 1ns/1ps
module sif_irq_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic tx_mode = 0, slave = 0, rise = 0, start = 0, stop = 0, match = 0;
  logic txmv = 0, rxmv = 0, txe = 0, rxf = 0, dacc = 0, rd = 0, wr = 0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic flag_o, dma_o, irq_o;

  int checks = 0, failures = 0;
  string cur_req = "R11";
  bit done = 0;

  always #2 clk = ~clk;

  sif_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .tx_mode_i(tx_mode), .slave_mode_i(slave),
    .bit_clk_rise_i(rise), .start_det_i(start), .stop_det_i(stop), .addr_match_i(match),
    .tx_move_i(txmv), .rx_move_i(rxmv), .tx_empty_i(txe), .rx_full_i(rxf),
    .dma_access_i(dacc), .reg_rd_i(rd), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .int_flag_o(flag_o), .dma_req_o(dma_o), .irq_o(irq_o)
  );

  // behavioural reference
  bit m_flag, m_dma, m_en, m_arm, m_hold;
  int m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag = 0; m_dma = 0; m_en = 0; m_arm = 0; m_hold = 0; m_cnt = 0;
    end else begin
      bit fire, bufev, iset, dset, clr, n_arm, n_hold;
      int tgt;
      fire = 0;
      tgt = (mode == 2'd1) ? 8 : 9;
      if (mode != 2'd1 && mode != 2'd2) m_cnt = 0;
      else if (start) m_cnt = 0;
      else if (rise) begin
        m_cnt++;
        if (m_cnt == tgt) begin fire = 1; m_cnt = 0; end
      end
      bufev = (start && tx_mode && txe) || (txmv && txe) || (rxmv && rxf);
      iset = fire || (start && mode == 2'd1) || (wr && wdata[3]) || bufev;
      dset = bufev && !m_hold;
      clr = (wr && !wdata[0] && m_arm) || dacc;
      n_arm = wr ? 1'b0 : ((rd && m_flag) ? 1'b1 : m_arm);
      n_hold = (match && slave && mode == 2'd0) ? 1'b1 : ((start || stop) ? 1'b0 : m_hold);
      if (iset) m_flag = 1; else if (clr) m_flag = 0;
      if (dset) m_dma = 1; else if (clr) m_dma = 0;
      if (wr) m_en = wdata[2];
      m_arm = n_arm;
      m_hold = n_hold;
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check({cur_req, " flag"}, {7'd0, flag_o}, {7'd0, m_flag});
      check({cur_req, " dma"},  {7'd0, dma_o},  {7'd0, m_dma});
      check({cur_req, " irq"},  {7'd0, irq_o},  {7'd0, m_flag & m_en});
      check({cur_req, " rdata"}, rdata, {5'd0, m_en, m_dma, m_flag});
    end
  end

  task automatic tick();
    @(negedge clk);
    {rise, start, stop, match, txmv, rxmv, dacc, rd, wr} = '0;
    wdata = 8'h00;
  endtask

  task automatic wreg(logic [7:0] d);
    wr = 1; wdata = d; tick();
  endtask

  task automatic rreg();
    rd = 1; tick();
  endtask

  task automatic cpu_clear();
    rreg(); wreg(8'h04);
  endtask

  task automatic rises(int n);
    for (int i = 0; i < n; i++) begin rise = 1; tick(); end
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R11 reset out", {5'd0, irq_o, dma_o, flag_o}, 8'h00);
    check("R11 reset rdata", rdata, 8'h00);
    tick();

    cur_req = "R10";
    wreg(8'h04);
    check("R10 enable reads back", rdata, 8'h04);
    cur_req = "R4";
    wreg(8'h0C);
    check("R4 sw trigger sets flag", {7'd0, flag_o}, 8'h01);
    check("R10 irq follows flag", {7'd0, irq_o}, 8'h01);
    check("R4 bit3 reads 0", rdata & 8'h08, 8'h00);
    wreg(8'h01);
    check("R10 irq masked", {7'd0, irq_o}, 8'h00);
    wreg(8'h05);

    cur_req = "R6";
    wreg(8'h04);
    check("R6 unarmed write0 keeps", {7'd0, flag_o}, 8'h01);
    rreg(); wreg(8'h05);
    check("R6 write1 keeps", {7'd0, flag_o}, 8'h01);
    wreg(8'h04);
    check("R6 write disarms", {7'd0, flag_o}, 8'h01);
    cpu_clear();
    check("R6 handshake clears", {7'd0, flag_o}, 8'h00);

    cur_req = "R1";
    mode = 2'd1; tick();
    rises(7);
    check("R1 7th edge no set", {7'd0, flag_o}, 8'h00);
    rises(1);
    check("R1 8th edge sets", {7'd0, flag_o}, 8'h01);
    cpu_clear();
    rises(7);
    check("R1 count restarted", {7'd0, flag_o}, 8'h00);
    rises(1);
    check("R1 second byte sets", {7'd0, flag_o}, 8'h01);
    cpu_clear();

    cur_req = "R3";
    rises(3); start = 1; tick();
    check("R3 sync start sets", {7'd0, flag_o}, 8'h01);
    cpu_clear();
    rises(7);
    check("R1 start restarts count", {7'd0, flag_o}, 8'h00);
    rises(1);
    check("R1 8 after start sets", {7'd0, flag_o}, 8'h01);
    cpu_clear();

    cur_req = "R2";
    mode = 2'd2; tick();
    start = 1; tick();
    check("R2 start no set formatless", {7'd0, flag_o}, 8'h00);
    rises(8);
    check("R2 8th edge no set", {7'd0, flag_o}, 8'h00);
    rises(1);
    check("R2 9th edge sets", {7'd0, flag_o}, 8'h01);
    cpu_clear();

    cur_req = "R5";
    mode = 2'd0; tick();
    start = 1; tick();
    check("R3 I2C start no set", {7'd0, flag_o}, 8'h00);
    txmv = 1; tick();
    check("R5 move without empty", {6'd0, dma_o, flag_o}, 8'h00);
    txe = 1; txmv = 1; tick();
    check("R5 tx move sets both", {6'd0, dma_o, flag_o}, 8'h03);
    cpu_clear();
    check("R6 clear drops dma", {6'd0, dma_o, flag_o}, 8'h00);
    rxmv = 1; tick();
    check("R5 rx move without full", {6'd0, dma_o, flag_o}, 8'h00);
    rxf = 1; rxmv = 1; tick();
    check("R5 rx move sets both", {6'd0, dma_o, flag_o}, 8'h03);

    cur_req = "R7";
    dacc = 1; tick();
    check("R7 dma access clears", {6'd0, dma_o, flag_o}, 8'h00);
    cur_req = "R5";
    tx_mode = 1; start = 1; tick();
    check("R5 start in tx empty", {6'd0, dma_o, flag_o}, 8'h03);
    dacc = 1; tick();
    tx_mode = 0; txe = 0;

    cur_req = "R8";
    slave = 1; match = 1; tick();
    rxmv = 1; tick();
    check("R8 hold blocks dma", {6'd0, dma_o, flag_o}, 8'h01);
    dacc = 1; tick();
    stop = 1; tick();
    rxmv = 1; tick();
    check("R8 stop ends hold", {6'd0, dma_o, flag_o}, 8'h03);
    dacc = 1; tick();
    match = 1; tick();
    start = 1; tick();
    rxmv = 1; tick();
    check("R8 restart ends hold", {6'd0, dma_o, flag_o}, 8'h03);
    slave = 0;

    cur_req = "R9";
    rreg();
    rxmv = 1; wr = 1; wdata = 8'h04; tick();
    check("R9 set beats cpu clear", {6'd0, dma_o, flag_o}, 8'h03);
    wreg(8'h0C); dacc = 1; wr = 0; tick();
    rxmv = 1; dacc = 1; tick();
    check("R9 set beats dma clear", {6'd0, dma_o, flag_o}, 8'h03);
    dacc = 1; tick();
    check("R7 final clear", {6'd0, dma_o, flag_o}, 8'h00);

    tick(); tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule